// File: doc/BRIEF.md
# Pulse-Position Radio Control Frame Decoder

This block turns a pulse-position-modulated radio-control stream into a set of channel values. A capture stage in front of it samples the input pin and presents, on every rising and on every falling transition, a 16-bit free-running microsecond timestamp together with a one-cycle strobe. The decoder works only on the spacing between consecutive timestamps. A long quiet period separates frames. Each channel is a short sync pulse followed by a gap. The channel value is the time from one pulse's leading edge to the next pulse's leading edge.

Inside a frame, an edge-tracking state machine checks every sync pulse width and every mark-to-mark interval against fixed windows. Accepted intervals are collected in a scratch buffer. A frame is published to the output registers only when its channel count matches a count that has already proven stable over several frames. When that happens, a one-cycle pulse marks the update. Any malformed edge drops the decoder out of lock. It then waits for the next long gap before decoding again.

Top module: `ppm_frame_decoder`

## Requirements
- R1: After reset every channel output, the accepted channel count and the frame length are 0, and the publish pulse is low.
- R2: Edge spacing is the current timestamp minus the previous one, taken modulo 2^16. A frame that straddles the timestamp rollover therefore decodes the same as any other frame.
- R3: A spacing of 2300 or more is a frame gap in every phase. It closes the frame, sets the frame's channel index to 0 and makes the next edge the expected end of a sync pulse.
- R4: While the decoder is out of lock (the phase after reset or after an error), edges shorter than a frame gap change nothing that can be observed: no frame length update, no channel storage and no publish.
- R5: The sync pulse after a gap, and each pulse after a stored channel, must be 200 to 600 inclusive wide. A pulse outside that window is an error.
- R6: A channel interval, measured from the previous mark to the current edge, must be 800 to 2200 inclusive. A valid interval is stored at the frame's current channel index. An interval outside the window is an error.
- R7: On each valid sync pulse after a gap, the frame length output becomes the time from the previous frame's opening gap edge to this frame's opening gap edge.
- R8: When a frame closes with a channel count equal to the accepted count, channels 0 to count-1 are copied to the outputs and the publish output is high for exactly one cycle. Outputs above the count, and all outputs between publishes, keep their values.
- R9: A closing count that differs from the accepted count becomes a candidate with a hold-off of 4. Each further frame with that count lowers the hold-off by one. The frame that finds it at 0 makes the candidate the accepted count, with no publish in that frame. The first publish therefore comes on the seventh identical frame. A different count restarts the candidate, and a frame matching the accepted count still publishes while a candidate is pending.
- R10: At most 20 channels are stored per frame. Further valid intervals are checked but discarded, and the count stays at 20.
- R11: An error sets the accepted count to 0 and leaves the channel outputs unchanged.
- R12: A frame with fewer than 5 channels is never published, even when its count is the accepted one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| edge_valid | input | 1 | One-cycle strobe: a transition was captured |
| edge_time | input | 16 | Microsecond timestamp of the captured transition |
| chan_vals | output | 320 | Published channel values, channel k at bits 16k+15:16k |
| chan_count | output | 5 | Accepted channel count (0 when out of lock) |
| frame_len | output | 16 | Length of the last complete frame in microseconds |
| frame_pub | output | 1 | High for one cycle when the channel outputs are updated |

## Verification
The main function is driven with whole frames of 8 channels whose values, sync widths and gap lengths vary from row to row. This covers both ends of the sync window and a gap of exactly 2300, and shows that the value and frame length paths follow the input rather than a fixed pattern. One frame is placed so that it starts just before the timestamp rolls over, which separates modular from plain subtraction. Sequences of frames with changing counts (8 to 6, 22, and 4) separate the candidate hold-off, the 20-channel cap and the minimum count. Each of the four windows is then violated just outside its bound to show that an error drops lock without disturbing the published values.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

  // Decoder phases: waiting for a gap, expecting end of sync pulse,
  // expecting a channel mark, expecting end of the pulse after a mark.
  typedef enum logic [1:0] {
    PH_HUNT  = 2'd0,
    PH_PRIME = 2'd1,
    PH_MARK  = 2'd2,
    PH_SPACE = 2'd3
  } ppm_phase_e;

  // Difference a - b reduced to w bits (timestamp rollover).
  function automatic logic [31:0] wrap_diff(input logic [31:0] a,
                                            input logic [31:0] b,
                                            input int unsigned w);
    logic [31:0] mask;
    mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (a - b) & mask;
  endfunction

  // Inclusive window test.
  function automatic logic in_window(input logic [31:0] v,
                                     input logic [31:0] lo,
                                     input logic [31:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

endpackage

// File: rtl/ppm_edge_tracker.sv
module ppm_edge_tracker
  import ppm_pkg::*;
#(
  parameter int unsigned TS_W    = 16,
  parameter int unsigned MAX_CH  = 20,
  parameter int unsigned CW      = 5,
  parameter int unsigned GAP_MIN = 2300,
  parameter int unsigned SYNC_LO = 200,
  parameter int unsigned SYNC_HI = 600,
  parameter int unsigned IVL_LO  = 800,
  parameter int unsigned IVL_HI  = 2200
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            edge_valid,
  input  logic [TS_W-1:0] edge_time,
  output ppm_phase_e      phase,
  output logic [CW-1:0]   frame_cnt,
  output logic            gap_evt,
  output logic            err_evt,
  output logic            store_evt,
  output logic [CW-1:0]   store_idx,
  output logic [TS_W-1:0] store_val,
  output logic [TS_W-1:0] frame_len
);

  logic [TS_W-1:0] last_edge;
  logic [TS_W-1:0] last_mark;
  logic [TS_W-1:0] frame_start;
  logic [TS_W-1:0] width;
  logic [TS_W-1:0] ivl;
  logic            sync_ok;
  logic            ivl_ok;
  logic            pulse_phase;
  logic            room;

  assign width = TS_W'(wrap_diff(32'(edge_time), 32'(last_edge), TS_W));
  assign ivl   = TS_W'(wrap_diff(32'(edge_time), 32'(last_mark), TS_W));

  assign sync_ok     = in_window(32'(width), SYNC_LO, SYNC_HI);
  assign ivl_ok      = in_window(32'(ivl), IVL_LO, IVL_HI);
  assign pulse_phase = (phase == PH_PRIME) || (phase == PH_SPACE);
  assign room        = 32'(frame_cnt) < MAX_CH;

  assign gap_evt   = edge_valid && (32'(width) >= GAP_MIN);
  assign err_evt   = edge_valid && !gap_evt &&
                     ((pulse_phase && !sync_ok) ||
                      ((phase == PH_MARK) && !ivl_ok));
  assign store_evt = edge_valid && !gap_evt && (phase == PH_MARK) &&
                     ivl_ok && room;
  assign store_idx = frame_cnt;
  assign store_val = ivl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= PH_HUNT;
      last_edge   <= '0;
      last_mark   <= '0;
      frame_start <= '0;
      frame_cnt   <= '0;
      frame_len   <= '0;
    end else if (edge_valid) begin
      if (gap_evt) begin
        frame_cnt <= '0;
        phase     <= PH_PRIME;
        last_edge <= edge_time;
      end else if (err_evt) begin
        // the edge reference is kept; the mark reference moves on a mark edge
        phase <= PH_HUNT;
        if (phase == PH_MARK) last_mark <= edge_time;
      end else begin
        unique case (phase)
          PH_HUNT: begin
            last_edge <= edge_time;
          end
          PH_PRIME: begin
            last_mark   <= last_edge;
            frame_len   <= TS_W'(wrap_diff(32'(last_edge), 32'(frame_start), TS_W));
            frame_start <= last_edge;
            phase       <= PH_MARK;
            last_edge   <= edge_time;
          end
          PH_SPACE: begin
            phase     <= PH_MARK;
            last_edge <= edge_time;
          end
          PH_MARK: begin
            last_mark <= edge_time;
            if (store_evt) frame_cnt <= frame_cnt + CW'(1);
            phase     <= PH_SPACE;
            last_edge <= edge_time;
          end
          default: phase <= PH_HUNT;
        endcase
      end
    end
  end

endmodule

// File: rtl/ppm_count_lock.sv
module ppm_count_lock #(
  parameter int unsigned CW     = 5,
  parameter int unsigned MIN_CH = 5,
  parameter int unsigned LOCK   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gap_evt,
  input  logic          err_evt,
  input  logic [CW-1:0] frame_cnt,
  output logic [CW-1:0] accepted,
  output logic          pub_req
);

  localparam int unsigned HW = $clog2(LOCK + 1);

  logic [CW-1:0] cand;
  logic [HW-1:0] hold;

  assign pub_req = gap_evt && (frame_cnt == accepted) && (32'(frame_cnt) >= MIN_CH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accepted <= '0;
      cand     <= '0;
      hold     <= '0;
    end else if (gap_evt) begin
      if (frame_cnt != accepted) begin
        if (cand != frame_cnt) begin
          cand <= frame_cnt;
          hold <= HW'(LOCK);
        end else if (hold != '0) begin
          hold <= hold - HW'(1);
        end else begin
          accepted <= cand;
          cand     <= '0;
        end
      end
    end else if (err_evt) begin
      accepted <= '0;
    end
  end

endmodule

// File: rtl/ppm_chan_store.sv
module ppm_chan_store #(
  parameter int unsigned TS_W   = 16,
  parameter int unsigned MAX_CH = 20,
  parameter int unsigned CW     = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   store_evt,
  input  logic [CW-1:0]          store_idx,
  input  logic [TS_W-1:0]        store_val,
  input  logic                   pub_req,
  input  logic [CW-1:0]          frame_cnt,
  output logic [MAX_CH*TS_W-1:0] chan_vals,
  output logic                   publish
);

  for (genvar g = 0; g < MAX_CH; g++) begin : g_slot
    logic [TS_W-1:0] scratch_q;
    logic [TS_W-1:0] held_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        scratch_q <= '0;
        held_q    <= '0;
      end else begin
        if (store_evt && (store_idx == CW'(g))) scratch_q <= store_val;
        if (pub_req && (frame_cnt > CW'(g)))    held_q    <= scratch_q;
      end
    end

    assign chan_vals[g*TS_W +: TS_W] = held_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) publish <= 1'b0;
    else        publish <= pub_req;
  end

endmodule

// File: rtl/ppm_frame_decoder.sv
module ppm_frame_decoder
  import ppm_pkg::*;
#(
  parameter int unsigned TS_W    = 16,
  parameter int unsigned MAX_CH  = 20,
  parameter int unsigned MIN_CH  = 5,
  parameter int unsigned LOCK    = 4,
  parameter int unsigned GAP_MIN = 2300,
  parameter int unsigned SYNC_LO = 200,
  parameter int unsigned SYNC_HI = 600,
  parameter int unsigned IVL_LO  = 800,
  parameter int unsigned IVL_HI  = 2200,
  localparam int unsigned CW     = $clog2(MAX_CH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   edge_valid,
  input  logic [TS_W-1:0]        edge_time,
  output logic [MAX_CH*TS_W-1:0] chan_vals,
  output logic [CW-1:0]          chan_count,
  output logic [TS_W-1:0]        frame_len,
  output logic                   frame_pub
);

  ppm_phase_e      phase;
  logic [CW-1:0]   frame_cnt;
  logic            gap_evt;
  logic            err_evt;
  logic            store_evt;
  logic [CW-1:0]   store_idx;
  logic [TS_W-1:0] store_val;
  logic            pub_req;

  ppm_edge_tracker #(
    .TS_W(TS_W), .MAX_CH(MAX_CH), .CW(CW), .GAP_MIN(GAP_MIN),
    .SYNC_LO(SYNC_LO), .SYNC_HI(SYNC_HI), .IVL_LO(IVL_LO), .IVL_HI(IVL_HI)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .edge_valid(edge_valid), .edge_time(edge_time),
    .phase(phase), .frame_cnt(frame_cnt), .gap_evt(gap_evt), .err_evt(err_evt),
    .store_evt(store_evt), .store_idx(store_idx), .store_val(store_val),
    .frame_len(frame_len)
  );

  ppm_count_lock #(
    .CW(CW), .MIN_CH(MIN_CH), .LOCK(LOCK)
  ) u_lock (
    .clk(clk), .rst_n(rst_n), .gap_evt(gap_evt), .err_evt(err_evt),
    .frame_cnt(frame_cnt), .accepted(chan_count), .pub_req(pub_req)
  );

  ppm_chan_store #(
    .TS_W(TS_W), .MAX_CH(MAX_CH), .CW(CW)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .store_evt(store_evt), .store_idx(store_idx),
    .store_val(store_val), .pub_req(pub_req), .frame_cnt(frame_cnt),
    .chan_vals(chan_vals), .publish(frame_pub)
  );

endmodule

// File: rtl/ppm_decoder_checker.sv
module ppm_decoder_checker
  import ppm_pkg::*;
#(
  parameter int unsigned TS_W   = 16,
  parameter int unsigned MAX_CH = 20,
  parameter int unsigned CW     = 5,
  parameter int unsigned MIN_CH = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   frame_pub,
  input logic [MAX_CH*TS_W-1:0] chan_vals,
  input logic [CW-1:0]          chan_count,
  input logic [CW-1:0]          frame_cnt,
  input ppm_phase_e             phase,
  input logic                   gap_evt,
  input logic                   err_evt
);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pub |=> !frame_pub);

  a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_pub |-> $stable(chan_vals));

  a_r12_min_count: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pub |-> (32'(chan_count) >= MIN_CH));

  a_r11_error_clears: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> (chan_count == '0));

  a_r3_gap_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    gap_evt |=> ((phase == PH_PRIME) && (frame_cnt == '0)));

  a_r10_cap: assert property (@(posedge clk) disable iff (!rst_n)
    32'(frame_cnt) <= MAX_CH);

  a_r4_hunt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_HUNT) && !gap_evt) |=> ((phase == PH_HUNT) && $stable(frame_cnt)));

endmodule

bind ppm_frame_decoder ppm_decoder_checker #(
  .TS_W(TS_W), .MAX_CH(MAX_CH), .CW(CW), .MIN_CH(MIN_CH)
) u_checker (
  .clk(clk), .rst_n(rst_n), .frame_pub(frame_pub), .chan_vals(chan_vals),
  .chan_count(chan_count), .frame_cnt(frame_cnt), .phase(phase),
  .gap_evt(gap_evt), .err_evt(err_evt)
);

// File: tb/tb_ppm_frame_decoder.sv
module tb_ppm_frame_decoder;

  localparam int TS_W   = 16;
  localparam int MAX_CH = 20;
  localparam int CW     = 5;
  localparam int NROW   = 5;
  // columns: seed, channels, sync width, closing gap, expect publish, expect count
  localparam int TBL [NROW][6] = '{
    '{ 20, 8, 200, 2300, 1, 8},
    '{ 40, 8, 600, 5000, 1, 8},
    '{120, 8, 400, 3000, 1, 8},
    '{ 60, 6, 400, 3000, 0, 8},
    '{ 80, 8, 400, 3000, 1, 8}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic edge_valid = 1'b0;
  logic [TS_W-1:0] edge_time = '0;
  wire  [MAX_CH*TS_W-1:0] chan_vals;
  wire  [CW-1:0] chan_count;
  wire  [TS_W-1:0] frame_len;
  wire  frame_pub;

  ppm_frame_decoder dut (
    .clk(clk), .rst_n(rst_n), .edge_valid(edge_valid), .edge_time(edge_time),
    .chan_vals(chan_vals), .chan_count(chan_count), .frame_len(frame_len),
    .frame_pub(frame_pub)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  logic [15:0] now = '0;
  logic [15:0] gap_last = '0;
  logic [15:0] gap_prev = '0;
  logic [15:0] vals [22];
  logic [15:0] expv [20];
  logic        pub_seen;
  logic [15:0] fl_seen;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] chan(input int i);
    return chan_vals[i*16 +: 16];
  endfunction

  task automatic send_edge(input logic [15:0] t);
    @(negedge clk);
    edge_time  = t;
    edge_valid = 1'b1;
    @(negedge clk);
    edge_valid = 1'b0;
    pub_seen   = frame_pub;
  endtask

  task automatic adv(input logic [15:0] d);
    now = now + d;
    send_edge(now);
  endtask

  task automatic send_gap(input logic [15:0] d);
    adv(d);
    gap_prev = gap_last;
    gap_last = now;
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 22; i++) vals[i] = 16'(1000 + 50 * i + seed);
  endtask

  task automatic send_frame(input int n, input int sw, input int gw);
    adv(16'(sw));
    fl_seen = frame_len;
    for (int i = 0; i < n; i++) begin
      adv(vals[i] - 16'(sw));
      adv(16'(sw));
    end
    send_gap(16'(gw));
  endtask

  task automatic take(input int n);
    for (int i = 0; i < n && i < 20; i++) expv[i] = vals[i];
  endtask

  task automatic check_outputs(input string req);
    for (int i = 0; i < 20; i++) chk(chan(i) == expv[i], req, int'(chan(i)), int'(expv[i]));
  endtask

  // seven identical frames: lock on the sixth, publish on the seventh (R9)
  task automatic lock_run(input int n, input int seed, input int prior, input string req);
    int neff;
    neff = (n > 20) ? 20 : n;
    fill(seed);
    for (int f = 1; f <= 7; f++) begin
      send_frame(n, 400, 3000);
      if (f <= 5) begin
        chk(!pub_seen, req, int'(pub_seen), 0);
        chk(int'(chan_count) == prior, req, int'(chan_count), prior);
      end else if (f == 6) begin
        chk(!pub_seen, req, int'(pub_seen), 0);
        chk(int'(chan_count) == neff, req, int'(chan_count), neff);
      end else if (neff >= 5) begin
        chk(pub_seen, req, int'(pub_seen), 1);
        take(neff);
        check_outputs(req);
      end else begin
        chk(!pub_seen, req, int'(pub_seen), 0);
        check_outputs(req);
      end
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #400000;
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [15:0] exp_fl;
    logic [15:0] fl_hold;
    logic [15:0] d;
    int sum;
    for (int i = 0; i < 20; i++) expv[i] = '0;

    // R1: reset state
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(chan_count == '0, "R1 count", int'(chan_count), 0);
    chk(frame_len == '0, "R1 frame_len", int'(frame_len), 0);
    chk(!frame_pub, "R1 publish", int'(frame_pub), 0);
    check_outputs("R1 channels");

    // R4: short edges before any gap are ignored
    adv(16'd400);
    adv(16'd400);
    chk(frame_len == '0, "R4 frame_len", int'(frame_len), 0);
    chk(chan_count == '0, "R4 count", int'(chan_count), 0);
    send_gap(16'd3000);

    // R9: initial lock on 8 channels
    lock_run(8, 0, 0, "R9 lock8");

    // table: R5 sync bounds, R3 gap of exactly 2300, R7 length, R8 publish/hold, R9 candidate
    for (int r = 0; r < NROW; r++) begin
      fill(TBL[r][0]);
      exp_fl = gap_last - gap_prev;
      send_frame(TBL[r][1], TBL[r][2], TBL[r][3]);
      chk(pub_seen == TBL[r][4][0], "R8 table publish", int'(pub_seen), TBL[r][4]);
      chk(int'(chan_count) == TBL[r][5], "R9 table count", int'(chan_count), TBL[r][5]);
      chk(fl_seen == exp_fl, "R7 table frame_len", int'(fl_seen), int'(exp_fl));
      if (TBL[r][4] != 0) take(TBL[r][1]);
      check_outputs("R8 table values");
    end

    // R2: steer the opening gap to 0xFF00 so the next frame crosses rollover
    fill(140);
    for (int k = 0; k < 2; k++) begin
      if (gap_last == 16'hFF00) break;
      sum = 400;
      for (int i = 0; i < 8; i++) sum += int'(vals[i]);
      d = 16'hFF00 - (now + 16'(sum));
      if (d < 16'd2300) d = d + 16'h8000;
      send_frame(8, 400, int'(d));
      chk(pub_seen, "R2 pre-wrap publish", int'(pub_seen), 1);
      take(8);
    end
    chk(gap_last == 16'hFF00, "R2 steering", int'(gap_last), 16'hFF00);
    fill(100);
    exp_fl = gap_last - gap_prev;
    send_frame(8, 400, 3000);
    chk(pub_seen, "R2 wrap publish", int'(pub_seen), 1);
    chk(fl_seen == exp_fl, "R7 wrap frame_len", int'(fl_seen), int'(exp_fl));
    take(8);
    check_outputs("R2 wrap values");

    // R9: candidate 6 was nominated in the table; five more 6-channel frames
    fill(10);
    for (int f = 1; f <= 5; f++) begin
      send_frame(6, 400, 3000);
      chk(!pub_seen, "R9 holdoff no publish", int'(pub_seen), 0);
      chk(int'(chan_count) == ((f == 5) ? 6 : 8), "R9 holdoff count", int'(chan_count),
          (f == 5) ? 6 : 8);
    end
    send_frame(6, 400, 3000);
    chk(pub_seen, "R9 publish after change", int'(pub_seen), 1);
    take(6);
    check_outputs("R8 upper channels held");

    // R6: interval bounds accepted
    fill(0);
    vals[0] = 16'd800;
    vals[1] = 16'd2200;
    send_frame(6, 400, 3000);
    chk(pub_seen, "R6 bounds publish", int'(pub_seen), 1);
    take(6);
    check_outputs("R6 bounds values");

    // R6/R11: interval 799 is an error
    fill(30);
    vals[0] = 16'd799;
    send_frame(6, 400, 3000);
    chk(chan_count == '0, "R11 count after 799", int'(chan_count), 0);
    chk(!pub_seen, "R6 799 no publish", int'(pub_seen), 0);
    check_outputs("R11 outputs held");

    // R5 low bound, then R4 in the hunting phase
    lock_run(6, 50, 0, "R9 relock a");
    adv(16'd199);
    chk(chan_count == '0, "R5 sync 199", int'(chan_count), 0);
    fl_hold = frame_len;
    adv(16'd400);
    adv(16'd400);
    chk(frame_len == fl_hold, "R4 frame_len held", int'(frame_len), int'(fl_hold));
    chk(!pub_seen, "R4 no publish", int'(pub_seen), 0);
    send_gap(16'd3000);

    // R5 high bound
    lock_run(6, 70, 0, "R9 relock b");
    fill(20);
    send_frame(6, 601, 3000);
    chk(chan_count == '0, "R5 sync 601", int'(chan_count), 0);
    check_outputs("R11 held after 601");

    // R6 high bound
    lock_run(6, 90, 0, "R9 relock c");
    fill(70);
    vals[2] = 16'd2201;
    send_frame(6, 400, 3000);
    chk(chan_count == '0, "R6 interval 2201", int'(chan_count), 0);
    check_outputs("R11 held after 2201");

    // R10: 22 channels cap at 20
    lock_run(22, 100, 0, "R10 cap");
    chk(int'(chan_count) == 20, "R10 count", int'(chan_count), 20);

    // R12: 4 channels lock but never publish
    lock_run(4, 0, 20, "R12 min count");
    chk(int'(chan_count) == 4, "R12 count", int'(chan_count), 4);

    finish_run();
  end

endmodule